// File: doc/BRIEF.md
# Lockable Clock Channel Selector Registers

This block holds one small control register for each peripheral clock channel. It sits behind a flat 32-bit register bus. Each register names the clock generator that should feed its channel and turns that channel on or off. Software writes the register once, sets its lock bit, and from then on the register cannot be changed again until the whole device is reset. Locking a channel also raises a lock line toward the generator that the channel points at, so the generator's own settings can be frozen as well. Generator 0 is never locked this way.

The enable bit is used in a slower target clock domain. It passes there through a two-stage synchronizer, and a second two-stage chain brings the synchronized value back to the bus clock. Reads of the enable bit return that returned value, not the written one. Software therefore polls the bit until it matches what was written. A per-channel busy flag shows the same mismatch in hardware.

Top module: `chan_clk_sel_regs`

## Requirements
- R1: After rst_n is held low, every channel register reads 0x00000000, every gen_lock line is low, and every chan_en_tgt and chan_busy bit is low.
- R2: Channel n (0..12) sits at byte address 0x80 + 4*n and decodes on the full address. A write to any other address (below 0x80, at 0xB4 or above, or not word aligned) changes no register, and a read of such an address returns 0.
- R3: In each register, bit 7 is the lock, bit 6 is the enable and bits 3:0 are the generator select. Bits 31:8 and 5:4 ignore writes and always read 0.
- R4: While a channel's lock bit is 1, every write to that channel is discarded. A write that sets the lock is itself stored in full, including its enable and select fields.
- R5: Writing 0 to the lock bit of a locked channel does not clear it. Only rst_n clears it.
- R6: gen_lock[g] for g in 1..3 is high exactly when at least one locked channel has generator select equal to g.
- R7: gen_lock[0] is never high. Select values 4..15 are stored and read back as written, but they raise no gen_lock line.
- R8: A channel's chan_en_tgt output follows the written enable bit after passing through a two-flop synchronizer clocked by tgt_clk.
- R9: Read bit 6 returns the enable value brought back to the bus clock from the target domain. chan_busy[n] is high while the written enable and the returned enable differ. It is high in the first cycle after a write that changes the enable, and it falls once the value has made the round trip.
- R10: chan_gen_sel carries the stored 4-bit generator select of channel n on bits [4n+3:4n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Synchronous active-low device reset, bus domain |
| tgt_clk | input | 1 | Target domain clock |
| tgt_rst_n | input | 1 | Synchronous active-low reset, target domain |
| req_valid | input | 1 | Bus access strobe |
| req_write | input | 1 | High for a write access |
| req_addr | input | 12 | Byte address for both reads and writes |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for req_addr, combinational |
| chan_gen_sel | output | 52 | Generator select of each channel, 4 bits per channel |
| chan_en_tgt | output | 13 | Enable of each channel, synchronized to tgt_clk |
| chan_busy | output | 13 | Enable round trip still in progress, per channel |
| gen_lock | output | 4 | Lock request toward each generator's control register |

## Verification
A lock flop that drops or fails to set shows up within one bus cycle: the next write to that channel is accepted, a read returns the new value, and the matching gen_lock line may fall. A wrong decode shows up on the first access to the neighbouring address, because a register other than the addressed one changes. A fault in the enable round trip leaves chan_busy stuck high, or lets bit 6 change in the cycle right after the write. The bench catches the stuck case through a bounded poll and the early change through a read made immediately after the write.

// File: rtl/chan_clk_sel_pkg.sv
// Package: shared field positions and the per-channel configuration type.
// Assumes a 32-bit register word and a 4-bit generator select field.
package chan_clk_sel_pkg;

    localparam int WORD_W   = 32;
    localparam int SEL_W    = 4;
    localparam int LOCK_POS = 7;
    localparam int EN_POS   = 6;
    localparam int SEL_LSB  = 0;

    // Stored state of one channel register
    typedef struct packed {
        logic             lock;
        logic             en;
        logic [SEL_W-1:0] sel;
    } chan_cfg_t;

    // Pull the stored fields out of a bus write word
    function automatic chan_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        chan_cfg_t c;
        c.lock = w[LOCK_POS];
        c.en   = w[EN_POS];
        c.sel  = w[SEL_LSB +: SEL_W];
        return c;
    endfunction

    // Build the read word: the enable bit comes from the returned value
    function automatic logic [WORD_W-1:0] word_from_cfg(input chan_cfg_t c,
                                                        input logic en_back);
        logic [WORD_W-1:0] w;
        w = '0;
        w[LOCK_POS]            = c.lock;
        w[EN_POS]              = en_back;
        w[SEL_LSB +: SEL_W]    = c.sel;
        return w;
    endfunction

endpackage

// File: rtl/chan_addr_dec.sv
// Address decoder: turns the bus address into one-hot channel selects.
// Assumes channels are word spaced from BASE_ADDR and decodes every address
// bit, so unaligned or out-of-range addresses hit no channel.
module chan_addr_dec #(
    parameter int          NUM_CH    = 13,
    parameter int          ADDR_W    = 12,
    parameter int unsigned BASE_ADDR = 32'h80,
    parameter int unsigned STRIDE    = 4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [NUM_CH-1:0] wr_hit,
    output logic [NUM_CH-1:0] rd_sel
);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
        localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(BASE_ADDR + STRIDE * n);
        // Read select follows the address alone; write hit needs a write strobe
        assign rd_sel[n] = (req_addr == CH_ADDR);
        assign wr_hit[n] = req_valid && req_write && rd_sel[n];
    end

endmodule

// File: rtl/chan_cfg_reg.sv
// One channel register with a sticky lock.
// Assumes rst_n is the device reset; a set lock blocks every later write.
module chan_cfg_reg
    import chan_clk_sel_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_hit,
    input  chan_cfg_t wr_cfg,
    output chan_cfg_t cfg_q
);

    // Store a write only while the channel is still unlocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_hit && !cfg_q.lock) begin
            cfg_q <= wr_cfg;
        end
    end

endmodule

// File: rtl/chan_en_cdc.sv
// Enable round trip: two flops into the target domain, two flops back.
// Assumes the enable is a level that stays put long enough to be seen;
// each domain has its own synchronous reset.
module chan_en_cdc #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgt_clk,
    input  logic tgt_rst_n,
    input  logic en_wr,
    output logic en_tgt,
    output logic en_ret
);

    logic [STAGES-1:0] fwd_q;
    logic [STAGES-1:0] back_q;

    // Carry the written enable into the target clock domain
    always_ff @(posedge tgt_clk) begin
        if (!tgt_rst_n) fwd_q <= '0;
        else            fwd_q <= {fwd_q[STAGES-2:0], en_wr};
    end

    // Carry the target-side enable back to the bus clock
    always_ff @(posedge clk) begin
        if (!rst_n) back_q <= '0;
        else        back_q <= {back_q[STAGES-2:0], fwd_q[STAGES-1]};
    end

    assign en_tgt = fwd_q[STAGES-1];
    assign en_ret = back_q[STAGES-1];

endmodule

// File: rtl/gen_lock_merge.sv
// Merges the channel locks into one lock line per generator.
// Assumes generator 0 may never be locked; selects at or above NUM_GEN match
// no generator.
module gen_lock_merge #(
    parameter int NUM_CH  = 13,
    parameter int NUM_GEN = 4,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_CH-1:0]       lock_vec,
    input  logic [NUM_CH*SEL_W-1:0] sel_flat,
    output logic [NUM_GEN-1:0]      gen_lock
);

    assign gen_lock[0] = 1'b0;

    for (genvar g = 1; g < NUM_GEN; g++) begin : g_gen
        // OR of every locked channel whose select names generator g
        always_comb begin
            gen_lock[g] = 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
                if (lock_vec[c] && (sel_flat[c*SEL_W +: SEL_W] == SEL_W'(g)))
                    gen_lock[g] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/chan_clk_sel_regs.sv
// Top: bank of lockable clock channel registers with enable synchronization.
// Assumes a single-cycle bus with a combinational read path; rst_n and
// tgt_rst_n are both asserted for a device reset.
module chan_clk_sel_regs
    import chan_clk_sel_pkg::*;
#(
    parameter int          NUM_CH    = 13,
    parameter int          NUM_GEN   = 4,
    parameter int          ADDR_W    = 12,
    parameter int unsigned BASE_ADDR = 32'h80
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tgt_clk,
    input  logic                    tgt_rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [WORD_W-1:0]       req_wdata,
    output logic [WORD_W-1:0]       rd_data,
    output logic [NUM_CH*SEL_W-1:0] chan_gen_sel,
    output logic [NUM_CH-1:0]       chan_en_tgt,
    output logic [NUM_CH-1:0]       chan_busy,
    output logic [NUM_GEN-1:0]      gen_lock
);

    localparam int STRIDE = WORD_W / 8;

    logic [NUM_CH-1:0]       wr_hit;
    logic [NUM_CH-1:0]       rd_sel;
    chan_cfg_t               wr_cfg;
    chan_cfg_t               cfg_q [NUM_CH];
    logic [NUM_CH-1:0]       lock_vec;
    logic [NUM_CH-1:0]       en_wr_vec;
    logic [NUM_CH-1:0]       en_ret_vec;
    logic [NUM_CH*SEL_W-1:0] sel_flat;
    logic                    unused_wbits;

    assign wr_cfg       = cfg_from_word(req_wdata);
    assign unused_wbits = ^{req_wdata[WORD_W-1:LOCK_POS+1],
                            req_wdata[EN_POS-1:SEL_LSB+SEL_W]};

    chan_addr_dec #(
        .NUM_CH   (NUM_CH),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .STRIDE   (STRIDE)
    ) u_dec (
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .wr_hit   (wr_hit),
        .rd_sel   (rd_sel)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        chan_cfg_reg u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_hit(wr_hit[n]),
            .wr_cfg(wr_cfg),
            .cfg_q (cfg_q[n])
        );

        chan_en_cdc #(.STAGES(2)) u_cdc (
            .clk      (clk),
            .rst_n    (rst_n),
            .tgt_clk  (tgt_clk),
            .tgt_rst_n(tgt_rst_n),
            .en_wr    (cfg_q[n].en),
            .en_tgt   (chan_en_tgt[n]),
            .en_ret   (en_ret_vec[n])
        );

        assign lock_vec[n]                  = cfg_q[n].lock;
        assign en_wr_vec[n]                 = cfg_q[n].en;
        assign sel_flat[n*SEL_W +: SEL_W]   = cfg_q[n].sel;
        assign chan_busy[n]                 = cfg_q[n].en ^ en_ret_vec[n];
    end

    assign chan_gen_sel = sel_flat;

    gen_lock_merge #(
        .NUM_CH (NUM_CH),
        .NUM_GEN(NUM_GEN),
        .SEL_W  (SEL_W)
    ) u_lock (
        .lock_vec(lock_vec),
        .sel_flat(sel_flat),
        .gen_lock(gen_lock)
    );

    // Return the addressed channel's word, or zero when no channel matches
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_sel[c]) rd_data = word_from_cfg(cfg_q[c], en_ret_vec[c]);
        end
    end

endmodule

// File: rtl/chan_clk_sel_chk.sv
// Checker: temporal properties on the lock state and the generator lock lines.
// Assumes it is bound to chan_clk_sel_regs and sees its internal vectors.
module chan_clk_sel_chk #(
    parameter int NUM_CH  = 13,
    parameter int NUM_GEN = 4,
    parameter int SEL_W   = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CH-1:0]       lock_vec,
    input logic [NUM_CH-1:0]       en_wr_vec,
    input logic [NUM_CH*SEL_W-1:0] sel_flat,
    input logic [NUM_GEN-1:0]      gen_lock
);

    // R7
    gen0_never_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_lock[0]);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R5
        lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lock_vec[i] |=> lock_vec[i]);
        // R4
        locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lock_vec[i] |=> ($stable(en_wr_vec[i]) &&
                             $stable(sel_flat[i*SEL_W +: SEL_W])));
    end

    for (genvar g = 1; g < NUM_GEN; g++) begin : g_gen
        // R6
        gen_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gen_lock[g] |=> gen_lock[g]);
        // R6
        gen_lock_needs_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gen_lock[g] |-> (lock_vec != '0));
    end

endmodule

bind chan_clk_sel_regs chan_clk_sel_chk #(
    .NUM_CH (NUM_CH),
    .NUM_GEN(NUM_GEN),
    .SEL_W  (chan_clk_sel_pkg::SEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_vec (lock_vec),
    .en_wr_vec(en_wr_vec),
    .sel_flat (sel_flat),
    .gen_lock (gen_lock)
);

// File: tb/sim_chan_clk_sel_regs.sv
`timescale 1ns/1ps
// Bench: table of write/read vectors, then directed lock, sync and reset tests.
module sim_chan_clk_sel_regs;

    localparam int NCH = 13;
    localparam int NGEN = 4;

    logic        clk = 1'b0;
    logic        tgt_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tgt_rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic [NCH*4-1:0] chan_gen_sel;
    logic [NCH-1:0]   chan_en_tgt;
    logic [NCH-1:0]   chan_busy;
    logic [NGEN-1:0]  gen_lock;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always #6.5 tgt_clk = ~tgt_clk;

    chan_clk_sel_regs u0 (
        .clk(clk), .rst_n(rst_n), .tgt_clk(tgt_clk), .tgt_rst_n(tgt_rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .chan_gen_sel(chan_gen_sel),
        .chan_en_tgt(chan_en_tgt), .chan_busy(chan_busy), .gen_lock(gen_lock)
    );

    localparam int NV = 10;
    localparam logic [11:0] V_WADDR [NV] = '{12'h080, 12'h094, 12'h0B0, 12'h08C, 12'h09C,
                                             12'h09C, 12'h07C, 12'h0B4, 12'h081, 12'h0A4};
    localparam logic [31:0] V_WDATA [NV] = '{32'h42, 32'h03, 32'h4F, 32'hFFFFFF3F, 32'h41,
                                             32'h00, 32'hFF, 32'hFF, 32'hC3, 32'h45};
    localparam logic [11:0] V_RADDR [NV] = '{12'h080, 12'h094, 12'h0B0, 12'h08C, 12'h09C,
                                             12'h09C, 12'h07C, 12'h0B4, 12'h080, 12'h0A4};
    localparam logic [31:0] V_REXP  [NV] = '{32'h42, 32'h03, 32'h4F, 32'h0F, 32'h41,
                                             32'h00, 32'h00, 32'h00, 32'h42, 32'h45};

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b0; req_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 40; k++) begin
            if (chan_busy == '0) break;
            @(negedge clk);
        end
        check(chan_busy == '0, "R9 busy clears", 64'(chan_busy), 64'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tgt_rst_n = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1; tgt_rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_all_zero();
        logic [31:0] d;
        for (int c = 0; c < NCH; c++) begin
            bus_rd(12'(12'h080 + 4 * c), d);
            check(d == 32'h0, "R1 reset value", 64'(d), 64'h0);
        end
        check(gen_lock == '0, "R1 gen_lock reset", 64'(gen_lock), 64'h0);
        check(chan_en_tgt == '0, "R1 chan_en_tgt reset", 64'(chan_en_tgt), 64'h0);
        check(chan_busy == '0, "R1 chan_busy reset", 64'(chan_busy), 64'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        do_reset();
        check_all_zero();

        // R2 R3 table walk: write, let the enable settle, read back
        for (int v = 0; v < NV; v++) begin
            bus_wr(V_WADDR[v], V_WDATA[v]);
            wait_idle();
            bus_rd(V_RADDR[v], d);
            check(d == V_REXP[v], "R2/R3 table readback", 64'(d), 64'(V_REXP[v]));
            check(gen_lock == '0, "R6 no lock while unlocked", 64'(gen_lock), 64'h0);
        end
        // R8 enables reached the target domain for ch0, ch12, ch9, not ch5/ch7
        check(chan_en_tgt == 13'h1201, "R8 target enables", 64'(chan_en_tgt), 64'h1201);
        // R10 select output for ch12 and ch3
        check(chan_gen_sel[51:48] == 4'hF, "R10 ch12 select", 64'(chan_gen_sel[51:48]), 64'hF);
        check(chan_gen_sel[15:12] == 4'hF, "R10 ch3 select", 64'(chan_gen_sel[15:12]), 64'hF);

        // R4 lock ch1 on generator 2, then try to change it
        bus_wr(12'h084, 32'h82);
        bus_rd(12'h084, d);
        check(d == 32'h82, "R4 lock write stored", 64'(d), 64'h82);
        check(gen_lock == 4'b0100, "R6 gen2 locked", 64'(gen_lock), 64'h4);
        bus_wr(12'h084, 32'h41);
        wait_idle();
        bus_rd(12'h084, d);
        check(d == 32'h82, "R4 locked write discarded", 64'(d), 64'h82);
        check(chan_en_tgt[1] == 1'b0, "R4 locked enable unchanged", 64'(chan_en_tgt[1]), 64'h0);
        bus_wr(12'h084, 32'h00);
        bus_rd(12'h084, d);
        check(d == 32'h82, "R5 lock not cleared by write", 64'(d), 64'h82);

        // R4 lock together with enable and select in one access
        bus_wr(12'h088, 32'hC3);
        wait_idle();
        bus_rd(12'h088, d);
        check(d == 32'hC3, "R4 lock plus fields", 64'(d), 64'hC3);
        check(gen_lock == 4'b1100, "R6 gen2 and gen3 locked", 64'(gen_lock), 64'hC);
        check(chan_en_tgt[2] == 1'b1, "R8 ch2 enabled in target", 64'(chan_en_tgt[2]), 64'h1);
        bus_wr(12'h088, 32'h00);
        wait_idle();
        bus_rd(12'h088, d);
        check(d == 32'hC3, "R4 ch2 frozen", 64'(d), 64'hC3);
        check(chan_en_tgt[2] == 1'b1, "R4 ch2 target enable kept", 64'(chan_en_tgt[2]), 64'h1);

        // R7 lock on generator 0 and on an out-of-range select
        bus_wr(12'h090, 32'h80);
        check(gen_lock == 4'b1100, "R7 gen0 stays unlocked", 64'(gen_lock), 64'hC);
        bus_wr(12'h098, 32'h89);
        bus_rd(12'h098, d);
        check(d == 32'h89, "R7 select 9 stored", 64'(d), 64'h89);
        check(gen_lock == 4'b1100, "R7 select 9 locks nothing", 64'(gen_lock), 64'hC);

        // R9 busy and read-back right after an enable write on ch8
        bus_wr(12'h0A0, 32'h40);
        check(chan_busy[8] == 1'b1, "R9 busy after write", 64'(chan_busy[8]), 64'h1);
        bus_rd(12'h0A0, d);
        check(d == 32'h00, "R9 enable not yet returned", 64'(d), 64'h0);
        check(chan_en_tgt[8] == 1'b0, "R8 not yet in target", 64'(chan_en_tgt[8]), 64'h0);
        wait_idle();
        bus_rd(12'h0A0, d);
        check(d == 32'h40, "R9 enable returned", 64'(d), 64'h40);
        check(chan_en_tgt[8] == 1'b1, "R8 ch8 in target", 64'(chan_en_tgt[8]), 64'h1);

        // R1 R5 device reset clears everything, locks included
        do_reset();
        check_all_zero();
        bus_wr(12'h084, 32'h05);
        bus_rd(12'h084, d);
        check(d == 32'h05, "R5 unlocked after reset", 64'(d), 64'h05);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule